// File: doc/BRIEF.md
# Flash Program/Erase Sequencer

This block sits on the host side of an asynchronous byte-wide flash bus. It turns a one-cycle request into the bus activity needed to program one byte or erase a sector, a block or the whole array. It first emits the unlock write cycles. Each write cycle has a setup cycle and WE# low and high widths counted in clock cycles, so the pulse timing of the memory can be met at any system clock. It then waits for the memory's internal operation by polling bit 6 of repeated reads at the target address.

Two successive equal reads of bit 6 mean the operation looks finished. A result that appears exactly at the moment of completion is rejected unless two further reads agree with it. Every read-back phase has a cycle budget that depends on the operation type. If the budget runs out, the block raises a timeout pulse instead of a done pulse, and in either case it returns to idle.

The data bus drive enable is active only while write cycles are on the bus. It drops for at least one cycle before OE# is lowered for a polling read. All bus pins come straight from flip-flops.

Top module: `flash_pe_seq`

## Requirements
- R1: During and after reset, and whenever the block is idle, CE#, OE# and WE# are high, the drive enable is low, the address and write data outputs are zero, and `req_ready` is high.
- R2: A request is taken only in a cycle where `req_ready` and `req_valid` are both high. `req_valid` asserted while an operation is in progress has no effect on the bus sequence.
- R3: Operation code 0 (byte program) writes four cycles as (address, data) pairs: (5555h, AAh), (2AAAh, 55h), (5555h, A0h), (request address, request data).
- R4: Operation codes 1 (sector erase), 2 (block erase) and 3 (chip erase) write six cycles: (5555h, AAh), (2AAAh, 55h), (5555h, 80h), (5555h, AAh), (2AAAh, 55h), then a final cycle. The final cycle is (request address, 30h) for code 1, (request address, 50h) for code 2 and (5555h, 10h) for code 3.
- R5: Each write cycle has one setup cycle with WE# high, then WE# low for `WE_LOW_CYC` cycles, then WE# high for `WE_HIGH_CYC` cycles. Address and data are constant across the whole write cycle, and CE# stays low from the first setup cycle to the end of polling. The first setup cycle appears in the cycle after the accepting edge.
- R6: The drive enable is high only during write cycles. Each polling read is preceded by `RD_GAP_CYC` cycles with OE# high and the drive enable low, and OE# is never low while the drive enable is high or WE# is low.
- R7: A polling read holds OE# low for `RD_LOW_CYC` cycles at the request address, with zero on the data outputs. Bit 6 of `fl_dq_in` is taken in the last of those cycles.
- R8: Completion is declared at the read whose bit 6 equals the three reads before it in the same operation. A pair of equal reads followed by a differing read does not complete, and polling continues.
- R9: In the cycle after the completing read, the block is idle with `op_done` high for exactly one cycle.
- R10: The polling phase lasts at most `TMO_PROG_CYC` cycles for code 0, `TMO_ERASE_CYC` for codes 1 and 2, and `TMO_CHIP_CYC` for code 3. When the last allowed cycle passes without completion, the next cycle is idle with `op_timeout` high for one cycle. A completion found in that last cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| req_addr | input | AW | Target byte, sector or block address |
| req_wdata | input | 8 | Byte to program |
| req_ready | output | 1 | High while idle |
| op_done | output | 1 | One-cycle completion pulse |
| op_timeout | output | 1 | One-cycle timeout pulse |
| fl_addr | output | AW | Flash address bus |
| fl_dq_out | output | 8 | Data driven onto the flash bus |
| fl_dq_oe | output | 1 | Drive enable for `fl_dq_out` |
| fl_dq_in | input | 8 | Data read from the flash bus |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write enable, active low |

## Verification
The first write setup cycle is due one cycle after the accepting edge. Each following phase starts exactly after the programmed cycle counts of the phases before it. The `op_done` or `op_timeout` pulse is due one cycle after the deciding polling cycle.

The bench builds the full expected pin vector of each operation, cycle by cycle, from the operation code and from the bit-6 script it plays back as the memory. It compares that vector with the pins at every falling clock edge, away from the edge where the registers update. The scripts include toggling, a false pair match, a broken confirmation, and budgets that expire in a gap cycle and in a read cycle.

// File: rtl/flash_seq_pkg.sv
`timescale 1ns/1ps
package flash_seq_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_BLK  = 2'd2,
        OP_CHIP = 2'd3
    } fop_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSET,
        ST_WLOW,
        ST_WHIGH,
        ST_RGAP,
        ST_RLOW
    } fst_e;

    localparam logic [14:0] KEY_ADDR_A = 15'h5555;
    localparam logic [14:0] KEY_ADDR_B = 15'h2AAA;
    localparam logic [7:0]  KEY_BYTE_1 = 8'hAA;
    localparam logic [7:0]  KEY_BYTE_2 = 8'h55;
    localparam logic [7:0]  CODE_PROG  = 8'hA0;
    localparam logic [7:0]  CODE_ERASE = 8'h80;
    localparam logic [7:0]  CODE_SECT  = 8'h30;
    localparam logic [7:0]  CODE_BLK   = 8'h50;
    localparam logic [7:0]  CODE_CHIP  = 8'h10;

    function automatic logic [2:0] slot_total(fop_e op);
        return (op == OP_PROG) ? 3'd4 : 3'd6;
    endfunction

endpackage

// File: rtl/flash_cmd_rom.sv
`timescale 1ns/1ps
module flash_cmd_rom
    import flash_seq_pkg::*;
#(
    parameter int AW = 20
) (
    input  fop_e            op,
    input  logic [2:0]      slot,
    input  logic [AW-1:0]   tgt,
    input  logic [7:0]      wdat,
    output logic [AW-1:0]   s_addr,
    output logic [7:0]      s_data
);
    localparam logic [AW-1:0] ADDR_A = AW'(KEY_ADDR_A);
    localparam logic [AW-1:0] ADDR_B = AW'(KEY_ADDR_B);

    // R3 / R4: slot contents of the unlock and command sequences
    always_comb begin
        s_addr = ADDR_A;
        s_data = KEY_BYTE_1;
        unique case (slot)
            3'd0: begin s_addr = ADDR_A; s_data = KEY_BYTE_1; end
            3'd1: begin s_addr = ADDR_B; s_data = KEY_BYTE_2; end
            3'd2: begin
                s_addr = ADDR_A;
                s_data = (op == OP_PROG) ? CODE_PROG : CODE_ERASE;
            end
            3'd3: begin
                if (op == OP_PROG) begin
                    s_addr = tgt;
                    s_data = wdat;
                end else begin
                    s_addr = ADDR_A;
                    s_data = KEY_BYTE_1;
                end
            end
            3'd4: begin s_addr = ADDR_B; s_data = KEY_BYTE_2; end
            default: begin
                unique case (op)
                    OP_SECT: begin s_addr = tgt;    s_data = CODE_SECT; end
                    OP_BLK:  begin s_addr = tgt;    s_data = CODE_BLK;  end
                    default: begin s_addr = ADDR_A; s_data = CODE_CHIP; end
                endcase
            end
        endcase
    end
endmodule

// File: rtl/flash_toggle_mon.sv
`timescale 1ns/1ps
module flash_toggle_mon #(
    parameter int CONFIRM_READS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic sample,
    input  logic bit6,
    output logic complete
);
    localparam int NEED = CONFIRM_READS + 1;
    localparam int RW   = $clog2(NEED + 1);

    typedef struct packed {
        logic          have;
        logic          prev;
        logic [RW-1:0] run;
    } tm_t;

    tm_t m_d, m_q;
    logic match;

    assign match    = m_q.have && (bit6 == m_q.prev);
    // R8: a matching pair plus the confirming reads must all agree
    assign complete = sample && match && (m_q.run == RW'(NEED - 1));

    always_comb begin
        m_d = m_q;
        if (clear) begin
            m_d = '0;
        end else if (sample) begin
            m_d.have = 1'b1;
            m_d.prev = bit6;
            if (match) begin
                if (m_q.run != RW'(NEED - 1)) begin
                    m_d.run = m_q.run + RW'(1);
                end
            end else begin
                m_d.run = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end
endmodule

// File: rtl/flash_poll_timer.sv
`timescale 1ns/1ps
module flash_poll_timer
    import flash_seq_pkg::*;
#(
    parameter int LIM_PROG  = 4000,
    parameter int LIM_ERASE = 5000000,
    parameter int LIM_CHIP  = 20000000
) (
    input  logic clk,
    input  logic rst_n,
    input  fop_e op,
    input  logic clear,
    input  logic run,
    output logic expire
);
    localparam int LIM_PE  = (LIM_PROG > LIM_ERASE) ? LIM_PROG : LIM_ERASE;
    localparam int LIM_MAX = (LIM_PE > LIM_CHIP) ? LIM_PE : LIM_CHIP;
    localparam int CW      = $clog2(LIM_MAX + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;
    logic [CW-1:0] limit;

    // R10: budget chosen by operation type
    always_comb begin
        unique case (op)
            OP_PROG: limit = CW'(LIM_PROG);
            OP_CHIP: limit = CW'(LIM_CHIP);
            default: limit = CW'(LIM_ERASE);
        endcase
    end

    assign expire = run && (t_q.cnt == limit - CW'(1));

    always_comb begin
        t_d = t_q;
        if (clear) begin
            t_d.cnt = '0;
        end else if (run && !expire) begin
            t_d.cnt = t_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end
endmodule

// File: rtl/flash_pe_seq.sv
`timescale 1ns/1ps
module flash_pe_seq
    import flash_seq_pkg::*;
#(
    parameter int AW            = 20,
    parameter int WE_LOW_CYC    = 8,
    parameter int WE_HIGH_CYC   = 6,
    parameter int RD_LOW_CYC    = 16,
    parameter int RD_GAP_CYC    = 4,
    parameter int CONFIRM_READS = 2,
    parameter int TMO_PROG_CYC  = 4000,
    parameter int TMO_ERASE_CYC = 5000000,
    parameter int TMO_CHIP_CYC  = 20000000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_wdata,
    output logic          req_ready,
    output logic          op_done,
    output logic          op_timeout,
    output logic [AW-1:0] fl_addr,
    output logic [7:0]    fl_dq_out,
    output logic          fl_dq_oe,
    input  logic [7:0]    fl_dq_in,
    output logic          fl_ce_n,
    output logic          fl_oe_n,
    output logic          fl_we_n
);
    localparam int PH_A   = (WE_LOW_CYC > WE_HIGH_CYC) ? WE_LOW_CYC : WE_HIGH_CYC;
    localparam int PH_B   = (RD_LOW_CYC > RD_GAP_CYC) ? RD_LOW_CYC : RD_GAP_CYC;
    localparam int PH_MAX = (PH_A > PH_B) ? PH_A : PH_B;
    localparam int PW     = $clog2(PH_MAX + 1);

    typedef struct packed {
        fst_e          st;
        logic [2:0]    slot;
        logic [PW-1:0] cnt;
        fop_e          op;
        logic [AW-1:0] tgt;
        logic [7:0]    wdat;
        logic [AW-1:0] addr;
        logic [7:0]    dout;
        logic          ce_n;
        logic          oe_n;
        logic          we_n;
        logic          dq_oe;
        logic          done;
        logic          err;
    } seq_t;

    seq_t r_d, r_q;

    fop_e          rom_op;
    logic [2:0]    rom_slot;
    logic [AW-1:0] rom_tgt;
    logic [7:0]    rom_wdat;
    logic [AW-1:0] rom_addr;
    logic [7:0]    rom_data;
    logic [PW-1:0] phase_len;
    logic          phase_end;
    logic          last_slot;
    logic          poll_clear;
    logic          poll_run;
    logic          sample;
    logic          complete;
    logic          expire;
    logic          unused_dq;

    assign unused_dq = ^{fl_dq_in[7], fl_dq_in[5:0]};

    // length of the phase held in the current state
    always_comb begin
        unique case (r_q.st)
            ST_WLOW:  phase_len = PW'(WE_LOW_CYC);
            ST_WHIGH: phase_len = PW'(WE_HIGH_CYC);
            ST_RGAP:  phase_len = PW'(RD_GAP_CYC);
            ST_RLOW:  phase_len = PW'(RD_LOW_CYC);
            default:  phase_len = PW'(1);
        endcase
    end

    assign phase_end  = (r_q.cnt == phase_len - PW'(1));
    assign last_slot  = (r_q.slot == slot_total(r_q.op) - 3'd1);
    assign poll_clear = (r_q.st == ST_WHIGH) && phase_end && last_slot;
    assign poll_run   = (r_q.st == ST_RGAP) || (r_q.st == ST_RLOW);
    assign sample     = (r_q.st == ST_RLOW) && phase_end; // R7

    // slot lookup: slot 0 of the incoming request while idle, else the next slot
    always_comb begin
        if (r_q.st == ST_IDLE) begin
            rom_op   = fop_e'(req_op);
            rom_tgt  = req_addr;
            rom_wdat = req_wdata;
            rom_slot = 3'd0;
        end else begin
            rom_op   = r_q.op;
            rom_tgt  = r_q.tgt;
            rom_wdat = r_q.wdat;
            rom_slot = r_q.slot + 3'd1;
        end
    end

    flash_cmd_rom #(.AW(AW)) u_rom (
        .op     (rom_op),
        .slot   (rom_slot),
        .tgt    (rom_tgt),
        .wdat   (rom_wdat),
        .s_addr (rom_addr),
        .s_data (rom_data)
    );

    flash_toggle_mon #(.CONFIRM_READS(CONFIRM_READS)) u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (poll_clear),
        .sample   (sample),
        .bit6     (fl_dq_in[6]),
        .complete (complete)
    );

    flash_poll_timer #(
        .LIM_PROG  (TMO_PROG_CYC),
        .LIM_ERASE (TMO_ERASE_CYC),
        .LIM_CHIP  (TMO_CHIP_CYC)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (r_q.op),
        .clear  (poll_clear),
        .run    (poll_run),
        .expire (expire)
    );

    // R1: bus state when returning to idle
    function automatic seq_t to_idle(seq_t s);
        seq_t o;
        o       = s;
        o.st    = ST_IDLE;
        o.cnt   = '0;
        o.addr  = '0;
        o.dout  = '0;
        o.ce_n  = 1'b1;
        o.oe_n  = 1'b1;
        o.we_n  = 1'b1;
        o.dq_oe = 1'b0;
        return o;
    endfunction

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                // R2: accept only while idle
                if (req_valid) begin
                    r_d.st    = ST_WSET;
                    r_d.op    = fop_e'(req_op);
                    r_d.tgt   = req_addr;
                    r_d.wdat  = req_wdata;
                    r_d.slot  = 3'd0;
                    r_d.cnt   = '0;
                    r_d.addr  = rom_addr;
                    r_d.dout  = rom_data;
                    r_d.ce_n  = 1'b0;
                    r_d.dq_oe = 1'b1;
                end
            end
            ST_WSET: begin
                // R5: one setup cycle, then WE# low
                r_d.st   = ST_WLOW;
                r_d.we_n = 1'b0;
                r_d.cnt  = '0;
            end
            ST_WLOW: begin
                if (phase_end) begin
                    r_d.st   = ST_WHIGH;
                    r_d.we_n = 1'b1;
                    r_d.cnt  = '0;
                end else begin
                    r_d.cnt = r_q.cnt + PW'(1);
                end
            end
            ST_WHIGH: begin
                if (phase_end) begin
                    r_d.cnt = '0;
                    if (last_slot) begin
                        // R6: release the bus before any read
                        r_d.st    = ST_RGAP;
                        r_d.dq_oe = 1'b0;
                        r_d.addr  = r_q.tgt;
                        r_d.dout  = '0;
                    end else begin
                        r_d.st   = ST_WSET;
                        r_d.slot = r_q.slot + 3'd1;
                        r_d.addr = rom_addr;
                        r_d.dout = rom_data;
                    end
                end else begin
                    r_d.cnt = r_q.cnt + PW'(1);
                end
            end
            ST_RGAP: begin
                if (expire) begin
                    r_d     = to_idle(r_q);
                    r_d.err = 1'b1;
                end else if (phase_end) begin
                    r_d.st   = ST_RLOW;
                    r_d.oe_n = 1'b0;
                    r_d.cnt  = '0;
                end else begin
                    r_d.cnt = r_q.cnt + PW'(1);
                end
            end
            ST_RLOW: begin
                // R9 before R10: completion on the last budget cycle wins
                if (sample && complete) begin
                    r_d      = to_idle(r_q);
                    r_d.done = 1'b1;
                end else if (expire) begin
                    r_d     = to_idle(r_q);
                    r_d.err = 1'b1;
                end else if (phase_end) begin
                    r_d.st   = ST_RGAP;
                    r_d.oe_n = 1'b1;
                    r_d.cnt  = '0;
                end else begin
                    r_d.cnt = r_q.cnt + PW'(1);
                end
            end
            default: begin
                r_d = to_idle(r_q);
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.ce_n <= 1'b1;
            r_q.oe_n <= 1'b1;
            r_q.we_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready  = (r_q.st == ST_IDLE);
    assign op_done    = r_q.done;
    assign op_timeout = r_q.err;
    assign fl_addr    = r_q.addr;
    assign fl_dq_out  = r_q.dout;
    assign fl_dq_oe   = r_q.dq_oe;
    assign fl_ce_n    = r_q.ce_n;
    assign fl_oe_n    = r_q.oe_n;
    assign fl_we_n    = r_q.we_n;
endmodule

// File: rtl/flash_pe_seq_chk.sv
`timescale 1ns/1ps
module flash_pe_seq_chk #(
    parameter int AW = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          op_done,
    input logic          op_timeout,
    input logic [AW-1:0] fl_addr,
    input logic [7:0]    fl_dq_out,
    input logic          fl_dq_oe,
    input logic          fl_ce_n,
    input logic          fl_oe_n,
    input logic          fl_we_n
);
    assert_idle_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (fl_ce_n && fl_oe_n && fl_we_n && !fl_dq_oe));

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_we_under_ce_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> !fl_ce_n);

    assert_stable_in_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out)));

    assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_oe_n |-> (!fl_dq_oe && fl_we_n));

    assert_done_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> (req_ready && !op_timeout));

    assert_timeout_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        op_timeout |-> req_ready);

    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !op_done);
endmodule

bind flash_pe_seq flash_pe_seq_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .op_done    (op_done),
    .op_timeout (op_timeout),
    .fl_addr    (fl_addr),
    .fl_dq_out  (fl_dq_out),
    .fl_dq_oe   (fl_dq_oe),
    .fl_ce_n    (fl_ce_n),
    .fl_oe_n    (fl_oe_n),
    .fl_we_n    (fl_we_n)
);

// File: tb/flash_pe_seq_tb.sv
`timescale 1ns/1ps
module flash_pe_seq_tb;
    localparam int AW = 20;
    localparam int WL = 3;
    localparam int WH = 2;
    localparam int RL = 2;
    localparam int RG = 1;
    localparam int LP = 40;
    localparam int LE = 80;
    localparam int LC = 120;
    localparam int WD = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_wdata = 8'h00;
    logic [7:0]    fl_dq_in = 8'h00;
    logic          req_ready, op_done, op_timeout;
    logic [AW-1:0] fl_addr;
    logic [7:0]    fl_dq_out;
    logic          fl_dq_oe, fl_ce_n, fl_oe_n, fl_we_n;

    always #2.5 clk = ~clk;

    flash_pe_seq #(
        .AW(AW), .WE_LOW_CYC(WL), .WE_HIGH_CYC(WH), .RD_LOW_CYC(RL),
        .RD_GAP_CYC(RG), .CONFIRM_READS(2),
        .TMO_PROG_CYC(LP), .TMO_ERASE_CYC(LE), .TMO_CHIP_CYC(LC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .op_done(op_done), .op_timeout(op_timeout), .fl_addr(fl_addr),
        .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in),
        .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
    );

    typedef struct packed {
        logic          ce;
        logic          oe;
        logic          we;
        logic          dqoe;
        logic [AW-1:0] a;
        logic [7:0]    d;
        logic          done;
        logic          err;
        logic          rdy;
    } vec_t;

    vec_t  exp_q[$];
    string tag_q[$];
    string ctx = "";
    int    n_tests = 0;
    int    n_fail = 0;
    int    cyc = 0;
    logic  fl_script[$];
    logic  fl_last = 1'b0;
    logic  prev_oe = 1'b1;

    function automatic vec_t idle_v();
        vec_t v;
        v = '0;
        v.ce = 1'b1; v.oe = 1'b1; v.we = 1'b1; v.rdy = 1'b1;
        return v;
    endfunction

    function automatic vec_t mk(logic ce, logic oe, logic we, logic dq,
                                logic [AW-1:0] a, logic [7:0] d);
        vec_t v;
        v = '0;
        v.ce = ce; v.oe = oe; v.we = we; v.dqoe = dq; v.a = a; v.d = d;
        return v;
    endfunction

    task automatic push(vec_t v, string t);
        exp_q.push_back(v);
        tag_q.push_back(t);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // one clock: memory model, then per-cycle comparison
    task automatic step();
        vec_t e, g;
        string t;
        logic cur;
        @(negedge clk);
        cyc++;
        if (!prev_oe && fl_oe_n && fl_script.size() > 0) fl_last = fl_script.pop_front();
        prev_oe = fl_oe_n;
        cur = (fl_script.size() > 0) ? fl_script[0] : fl_last;
        fl_dq_in = {1'b0, cur, 6'b0};
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
        end else begin
            e = idle_v();
            t = "R1";
        end
        g = '{ce: fl_ce_n, oe: fl_oe_n, we: fl_we_n, dqoe: fl_dq_oe, a: fl_addr,
              d: fl_dq_out, done: op_done, err: op_timeout, rdy: req_ready};
        n_tests++;
        if (g !== e) begin
            n_fail++;
            $display("FAIL %s%s cycle %0d: actual %h expected %h", ctx, t, cyc, g, e);
        end
        if (cyc > WD) begin
            n_fail++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_run();
        end
    endtask

    // behavioural prediction of a whole operation
    task automatic expect_op(logic [1:0] op, logic [AW-1:0] ta, logic [7:0] wd, logic scr[$]);
        logic [AW-1:0] sa[6];
        logic [7:0]    sd[6];
        int            ns, lim, pc;
        string         ct;
        logic          hist[$];
        logic          b;
        vec_t          v;
        ns = (op == 2'd0) ? 4 : 6;
        lim = (op == 2'd0) ? LP : ((op == 2'd3) ? LC : LE);
        ct = (op == 2'd0) ? "R3" : "R4";
        sa[0] = 20'h05555; sd[0] = 8'hAA;
        sa[1] = 20'h02AAA; sd[1] = 8'h55;
        sa[2] = 20'h05555; sd[2] = (op == 2'd0) ? 8'hA0 : 8'h80;
        if (op == 2'd0) begin
            sa[3] = ta; sd[3] = wd;
            sa[4] = '0; sd[4] = '0; sa[5] = '0; sd[5] = '0;
        end else begin
            sa[3] = 20'h05555; sd[3] = 8'hAA;
            sa[4] = 20'h02AAA; sd[4] = 8'h55;
            sa[5] = (op == 2'd3) ? 20'h05555 : ta;
            sd[5] = (op == 2'd1) ? 8'h30 : ((op == 2'd2) ? 8'h50 : 8'h10);
        end
        for (int s = 0; s < ns; s++) begin
            push(mk(0, 1, 1, 1, sa[s], sd[s]), ct);
            for (int i = 0; i < WL; i++) push(mk(0, 1, 0, 1, sa[s], sd[s]), "R5");
            for (int i = 0; i < WH; i++) push(mk(0, 1, 1, 1, sa[s], sd[s]), "R5");
        end
        pc = 0;
        forever begin
            for (int g = 0; g < RG; g++) begin
                pc++;
                push(mk(0, 1, 1, 0, ta, 8'h00), "R6");
                if (pc == lim) begin
                    v = idle_v(); v.err = 1'b1; push(v, "R10");
                    return;
                end
            end
            for (int r = 0; r < RL; r++) begin
                pc++;
                push(mk(0, 0, 1, 0, ta, 8'h00), "R7");
                if (r == RL - 1) begin
                    b = (hist.size() < scr.size()) ? scr[hist.size()] : scr[scr.size() - 1];
                    hist.push_back(b);
                    if (hist.size() >= 4 &&
                        hist[hist.size()-1] == hist[hist.size()-2] &&
                        hist[hist.size()-2] == hist[hist.size()-3] &&
                        hist[hist.size()-3] == hist[hist.size()-4]) begin
                        v = idle_v(); v.done = 1'b1; push(v, "R8 R9");
                        return;
                    end
                end
                if (pc == lim) begin
                    v = idle_v(); v.err = 1'b1; push(v, "R10");
                    return;
                end
            end
        end
    endtask

    task automatic run_op(logic [1:0] op, logic [AW-1:0] ta, logic [7:0] wd,
                          logic scr[$], int poke_at);
        int c;
        step();
        fl_script = scr;
        req_valid = 1'b1; req_op = op; req_addr = ta; req_wdata = wd;
        expect_op(op, ta, wd, scr);
        step();
        req_valid = 1'b0;
        c = 0;
        while (exp_q.size() > 0) begin
            // R2: a request raised while busy must not disturb the sequence
            if (c == poke_at) begin
                req_valid = 1'b1; req_op = 2'd3; req_addr = 20'h11111; req_wdata = 8'hEE;
                ctx = "R2 ";
            end
            if (c == poke_at + 5) begin
                req_valid = 1'b0;
                ctx = "";
            end
            step();
            c++;
        end
        req_valid = 1'b0;
        ctx = "";
        step();
        step();
    endtask

    initial begin
        logic s[$];
        // R1: reset state
        for (int i = 0; i < 4; i++) step();
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) step();

        // R3 R7 R8 R9: program, toggling then settled, with a busy request (R2)
        s = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};
        run_op(2'd0, 20'hABCDE, 8'h3C, s, 4);

        // R4 R8: sector erase, equal pair followed by a differing read
        s = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
        run_op(2'd1, 20'h3F123, 8'h00, s, -10);

        // R4 R8: block erase, pair and one confirmation then a break
        s = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};
        run_op(2'd2, 20'h70000, 8'h00, s, 10);

        // R4: chip erase
        s = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
        run_op(2'd3, 20'h00400, 8'h00, s, -10);

        // R10: program budget runs out in a gap cycle
        s.delete();
        for (int i = 0; i < 20; i++) s.push_back(i[0]);
        run_op(2'd0, 20'h00077, 8'h5A, s, -10);

        // R10: chip budget runs out in a read cycle
        s.delete();
        for (int i = 0; i < 45; i++) s.push_back(i[0]);
        run_op(2'd3, 20'h00000, 8'h00, s, -10);

        // R1 R2: idle with no request leaves the bus quiet
        for (int i = 0; i < 4; i++) step();
        finish_run();
    end
endmodule